// File: doc/BRIEF.md
# Port Interrupt Glitch Filter

This block qualifies edges on a set of interrupt-capable general-purpose input pins. Every pin has its own run-length filter, and the filter takes one sample per clock. An edge counts as genuine only when at least four consecutive samples at the inactive level come first and four consecutive samples at the active level follow them. When the filter accepts an edge, it sets a sticky per-pin flag, which software clears by writing 1. A per-pin polarity bit selects whether the filter watches for rising or falling edges.

The sampling clock port carries the bus clock in run and wait modes. In stop mode it carries a low-power oscillator, and clock selection is done outside this block. The block drives an oscillator request output, asserted in stop mode only while at least one enabled pin with a clear flag can still change its interrupt outcome. This lets the oscillator stay off at all other times.

Top module: `port_irq_filter`

## Requirements
- R1: The flag of a pin is set on the clock edge that takes the fourth consecutive active-level sample, and only if four consecutive inactive-level samples were seen earlier. Active samples with no such inactive run before them set nothing.
- R2: Once four inactive samples have armed a pin, the pin stays armed across any later mix of samples until a run of four active samples fires it.
- R3: With `pol_rise` bit at 1 the active level is high (rising edges). With it at 0 the active level is low (falling edges).
- R4: A flag stays set until a cycle in which its `flag_clr` bit is 1. It then reads 0 after that edge, provided no new edge is accepted in the same cycle.
- R5: If a clear and an accepted edge fall in the same cycle, the flag is 1 after that edge.
- R6: `irq[i]` equals `flag[i]` AND `irq_en[i]`, with no clock delay.
- R7: `osc_req` is 1 only when `mode` is stop (2'b10; run is 2'b00, wait is 2'b01) and some pin meets all of these: its enable is 1, its flag is 0, and either its run count is 4 or less or its current level differs from the level of its run. A change in level raises the request with no clock delay.
- R8: When `rst_n` is low, all flags, counters and arming states are cleared asynchronously. `osc_req` is then 0 while enables are 0, and the filter treats the pin as inactive.
- R9: The run counter saturates and does not wrap. A pin held active after its edge was accepted and cleared does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (bus clock or stop-mode oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 run, 01 wait, 10 stop |
| pin_in | input | NPINS | Synchronized pin levels |
| pol_rise | input | NPINS | 1 = rising edge active, 0 = falling |
| irq_en | input | NPINS | Per-pin interrupt enable |
| flag_clr | input | NPINS | Write-1-to-clear strobe for each flag |
| flag | output | NPINS | Sticky edge-detected flags |
| irq | output | NPINS | Interrupt requests |
| osc_req | output | 1 | Request to run the stop-mode oscillator |

## Verification
Two functions can fall in the same cycle: a software clear of a flag and the acceptance of a new edge on the same pin. The bench arms the pin with four inactive samples and then gives three active ones. It raises `flag_clr` on the cycle that carries the fourth active sample. The flag must read 1 after that edge. A clear given together with an inactive sample must read 0 instead, which shows that the clear path works and that the set path wins the collision.

// File: rtl/pif_pkg.sv
package pif_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_STOP = 2'b10
    } pif_mode_e;
endpackage

// File: rtl/pif_pin_filter.sv
module pif_pin_filter #(
    parameter int SAMPLES = 4,
    parameter int CW      = $clog2(SAMPLES + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol_rise,
    input  logic ie,
    input  logic clr,
    output logic flag,
    output logic osc_need
);
    localparam logic [CW-1:0] RUN_LEN = CW'(SAMPLES);
    localparam logic [CW-1:0] CNT_SAT = CW'(SAMPLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run_act;
        logic          armed;
        logic          flag;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    active;
    logic    fire;

    always_comb begin
        active = pol_rise ? pin : ~pin;
        st_d   = st_q;
        if (active == st_q.run_act) begin
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.run_act = active;
            st_d.cnt     = CW'(1);
        end
        fire = st_q.armed && active && (st_d.cnt == RUN_LEN);
        if (!active && st_d.cnt == RUN_LEN) st_d.armed = 1'b1;
        if (fire) st_d.armed = 1'b0;
        st_d.flag = fire | (st_q.flag & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag     = st_q.flag;
    assign osc_need = ie & ~st_q.flag &
                      ((st_q.cnt <= RUN_LEN) | (active != st_q.run_act));
endmodule

// File: rtl/pif_osc_ctl.sv
module pif_osc_ctl #(
    parameter int NPINS = 2
) (
    input  logic [1:0]       mode,
    input  logic [NPINS-1:0] need,
    output logic             osc_req
);
    import pif_pkg::*;
    always_comb begin
        osc_req = (mode == MODE_STOP) && (|need);
    end
endmodule

// File: rtl/port_irq_filter.sv
module port_irq_filter #(
    parameter int NPINS   = 2,
    parameter int SAMPLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pol_rise,
    input  logic [NPINS-1:0] irq_en,
    input  logic [NPINS-1:0] flag_clr,
    output logic [NPINS-1:0] flag,
    output logic [NPINS-1:0] irq,
    output logic             osc_req
);
    localparam int CW = $clog2(SAMPLES + 2);

    logic [NPINS-1:0] need;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pif_pin_filter #(.SAMPLES(SAMPLES), .CW(CW)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pin_in[g]),
            .pol_rise (pol_rise[g]),
            .ie       (irq_en[g]),
            .clr      (flag_clr[g]),
            .flag     (flag[g]),
            .osc_need (need[g])
        );
    end

    assign irq = flag & irq_en;

    pif_osc_ctl #(.NPINS(NPINS)) u_osc (
        .mode    (mode),
        .need    (need),
        .osc_req (osc_req)
    );
endmodule

// File: rtl/pif_checker.sv
module pif_checker #(
    parameter int NPINS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] pol_rise,
    input logic [NPINS-1:0] irq_en,
    input logic [NPINS-1:0] flag_clr,
    input logic [NPINS-1:0] flag,
    input logic             osc_req
);
    // R7
    osc_only_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_req |-> (mode == 2'b10));

    // R7
    osc_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_req |-> (irq_en != '0));

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R4
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !flag_clr[g]) |=> flag[g]);

        // R1
        flag_rise_on_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[g]) |-> $past(pol_rise[g] ? pin_in[g] : ~pin_in[g]));

        // R4
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[g] && !(pol_rise[g] ? pin_in[g] : ~pin_in[g])) |=> !flag[g]);
    end
endmodule

bind port_irq_filter pif_checker #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .pin_in   (pin_in),
    .pol_rise (pol_rise),
    .irq_en   (irq_en),
    .flag_clr (flag_clr),
    .flag     (flag),
    .osc_req  (osc_req)
);

// File: tb/tb_port_irq_filter.sv
`timescale 1ns/1ps
module tb_port_irq_filter;
    localparam int NPINS = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       mode;
    logic [NPINS-1:0] pin_in, pol_rise, irq_en, flag_clr;
    logic [NPINS-1:0] flag, irq;
    logic             osc_req;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    port_irq_filter #(.NPINS(NPINS), .SAMPLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .pin_in(pin_in),
        .pol_rise(pol_rise), .irq_en(irq_en), .flag_clr(flag_clr),
        .flag(flag), .irq(irq), .osc_req(osc_req)
    );

    // each entry: {pin0 level, expected flag0 after the edge}
    localparam int NVEC = 17;
    localparam logic [1:0] VEC [NVEC] = '{
        2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10,
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
        2'b10, 2'b10, 2'b10, 2'b11, 2'b11
    };

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step(input logic p0, input logic c0);
        pin_in[0]   = p0;
        flag_clr[0] = c0;
        @(posedge clk);
        #1;
        flag_clr[0] = 1'b0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'b00; pin_in = '0; pol_rise = 2'b11;
        irq_en = '0; flag_clr = '0;
        #10;
        // R8 reset state
        chk("R8 flag", flag[0], 1'b0);
        chk("R8 irq", irq[0], 1'b0);
        chk("R8 osc", osc_req, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1; irq_en = 2'b01;

        // R1 table walk, R6 irq follows flag with enable set
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][1], 1'b0);
            chk("R1 flag", flag[0], VEC[i][0]);
            chk("R6 irq", irq[0], VEC[i][0]);
        end

        // R4 clear with active level held
        step(1'b1, 1'b1);
        chk("R4 clear", flag[0], 1'b0);
        // R9 saturated count does not refire
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
        chk("R9 no refire", flag[0], 1'b0);

        // R2 armed survives an interrupted active run
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        chk("R2 third active", flag[0], 1'b0);
        step(1'b1, 1'b0);
        chk("R2 fourth active", flag[0], 1'b1);

        // R5 clear collides with accepted edge
        step(1'b0, 1'b1);
        chk("R4 clear passive", flag[0], 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R5 set wins", flag[0], 1'b1);

        // R3 falling-edge polarity
        pol_rise[0] = 1'b0;
        step(1'b1, 1'b1);
        chk("R3 cleared", flag[0], 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        chk("R3 third low", flag[0], 1'b0);
        step(1'b0, 1'b0);
        chk("R3 fourth low", flag[0], 1'b1);

        // R6 enable gates irq combinationally
        irq_en[0] = 1'b0; #1;
        chk("R6 irq masked", irq[0], 1'b0);
        chk("R6 flag kept", flag[0], 1'b1);

        // R7 oscillator request
        irq_en[0] = 1'b1; mode = 2'b10;
        step(1'b0, 1'b1);
        chk("R7 flag cleared", flag[0], 1'b0);
        chk("R7 idle long run", osc_req, 1'b0);
        pin_in[0] = 1'b1; #1;
        chk("R7 level change", osc_req, 1'b1);
        step(1'b1, 1'b0);
        chk("R7 short run", osc_req, 1'b1);
        mode = 2'b00; #1;
        chk("R7 run mode", osc_req, 1'b0);
        mode = 2'b10; irq_en = '0; #1;
        chk("R7 disabled", osc_req, 1'b0);

        // R8 asynchronous reset mid-run
        irq_en[0] = 1'b1;
        #1 rst_n = 1'b0; #1;
        chk("R8 async flag", flag[0], 1'b0);
        irq_en = '0; #1;
        chk("R8 async osc", osc_req, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule